// File: doc/BRIEF.md
# Scaler Setup Parameter Calculator

This block converts the source and destination dimensions of one display plane into the settings a pixel scaler needs. For each axis it reports whether the image is kept, enlarged or shrunk, and a 16-bit fixed-point step factor. For the vertical axis it also reports how many source lines are skipped ahead of a bilinear shrink. From the source width and the pixel format it also picks how the line buffer is organised.

A one-cycle `start` captures all inputs. The block then runs up to two divisions, one after the other, on a single shared restoring divider. It ends with a one-cycle `done`, and the results are valid in that cycle. The results stay unchanged until the next `done`. A `start` given in the same cycle as `done` is accepted, so jobs can run back to back. Degenerate sizes raise an error flag instead of producing a factor.

Top module: `scl_setup_calc`

## Requirements
- R1: A `start` sampled while idle captures the inputs. `busy` is high from the next cycle until the result is published. `done` is high for exactly one cycle with `busy` low. All result outputs change only on the edge that raises `done`. After reset, `done`, `busy`, `cfg_err` and all result outputs are zero.
- R2: A `start` sampled while `busy` is high is ignored. The running job's result is unaffected, and no further job follows it.
- R3: Per axis, the direction code is 0 when source equals destination, 1 when source is smaller (enlarge), and 2 when source is larger (shrink).
- R4: An axis with direction 0 reports the unity factor 0x1000, with no division.
- R5: On an enlarging axis the factor is ((2*src-3)<<15)/(dst-1), truncated to 16 bits. This holds for both filter choices: `filt_sel` 0 means bilinear and 1 means bicubic.
- R6: On a shrinking axis without line skip, the factor is ((2*src-3)<<11)/(dst-1), truncated to 16 bits.
- R7: `v_skip` is 4 when a vertical shrink uses bilinear filtering (`filt_sel`=0) and src_h >= 4*dst_h. It is 2 when src_h >= 2*dst_h. Otherwise it is 1. With averaging (`filt_sel`=1) or any other vertical direction it is 1.
- R8: With `v_skip` k > 1, the effective height is ceil(src_h/k). If that equals dst_h, the vertical factor is the R6 factor of src_h, truncated, then divided by k. Otherwise it is the R6 factor computed with the effective height as source.
- R9: `lb_mode` is 2 if src_w > 2560, else 3 if src_w > 1920, else 4 for RGB (`is_yuv`=0), else 0 if src_w > 1280, else 1.
- R10: If any of the four sizes is below 2, `cfg_err` is 1, both factors are 0 and `v_skip` is 1. Directions and `lb_mode` are still reported.
- R11: A `start` sampled in the cycle where `done` is high begins a new job.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation |
| src_w | input | SZ_W | Source width |
| src_h | input | SZ_W | Source height |
| dst_w | input | SZ_W | Destination width |
| dst_h | input | SZ_W | Destination height |
| is_yuv | input | 1 | Plane carries YUV data |
| filt_sel | input | 1 | Filter choice: bicubic when enlarging, averaging when shrinking |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| cfg_err | output | 1 | Degenerate size seen |
| h_dir | output | 2 | Horizontal direction code |
| v_dir | output | 2 | Vertical direction code |
| h_factor | output | 16 | Horizontal step factor |
| v_factor | output | 16 | Vertical step factor |
| v_skip | output | 3 | Vertical line skip (1, 2 or 4) |
| lb_mode | output | 3 | Line-buffer organisation code |

## Verification
Two events can land in the same cycle: publication of one result (`done`) and acceptance of the next `start`. The driver launches each new job at the very sample point where it sees `done` high. The monitor judges whether the published values belong to the finished job and whether the new job then produces its own correct result. A second overlap is a `start` arriving mid-job. It is checked by confirming that the outputs and the queue of expected results are both left untouched.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int          FACT_W     = 16;
  localparam logic [15:0] FACT_UNITY = 16'h1000;
  localparam int          SH_GROW    = 15;
  localparam int          SH_SHRINK  = 11;
  localparam logic [15:0] LB_TH_HI   = 16'd2560;
  localparam logic [15:0] LB_TH_MID  = 16'd1920;
  localparam logic [15:0] LB_TH_LO   = 16'd1280;

  typedef enum logic [1:0] {
    DIR_KEEP   = 2'd0,
    DIR_GROW   = 2'd1,
    DIR_SHRINK = 2'd2
  } scl_dir_e;

  typedef enum logic [2:0] {
    LBO_YUV_WIDE   = 3'd0,
    LBO_YUV_DEEP   = 3'd1,
    LBO_RGB_WIDE   = 3'd2,
    LBO_RGB_MID    = 3'd3,
    LBO_RGB_NARROW = 3'd4
  } lb_org_e;

  function automatic scl_dir_e dir_of(input logic [15:0] s, input logic [15:0] d);
    if (s == d)     return DIR_KEEP;
    else if (s < d) return DIR_GROW;
    else            return DIR_SHRINK;
  endfunction

  function automatic lb_org_e lb_pick(input logic [15:0] w, input logic yuv);
    if (w > LB_TH_HI)       return LBO_RGB_WIDE;
    else if (w > LB_TH_MID) return LBO_RGB_MID;
    else if (!yuv)          return LBO_RGB_NARROW;
    else if (w > LB_TH_LO)  return LBO_YUV_WIDE;
    else                    return LBO_YUV_DEEP;
  endfunction
endpackage

// File: rtl/scl_rdiv.sv
module scl_rdiv #(
  parameter int NUM_W = 29,
  parameter int DEN_W = 13,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [OUT_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W);

  logic             run_q, run_n, fin_q, fin_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DEN_W-1:0] rem_q, rem_n, den_q, den_n;
  logic [NUM_W-1:0] quo_q, quo_n;
  logic [DEN_W:0]   trial, diff;
  logic             take;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    take  = (trial >= {1'b0, den_q});
  end

  always_comb begin
    run_n = run_q;
    fin_n = 1'b0;
    cnt_n = cnt_q;
    rem_n = rem_q;
    den_n = den_q;
    quo_n = quo_q;
    if (go) begin
      run_n = 1'b1;
      cnt_n = '0;
      rem_n = '0;
      den_n = den;
      quo_n = num;
    end else if (run_q) begin
      rem_n = take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_n = {quo_q[NUM_W-2:0], take};
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
    end else begin
      run_q <= run_n;
      fin_q <= fin_n;
      cnt_q <= cnt_n;
      rem_q <= rem_n;
      den_q <= den_n;
      quo_q <= quo_n;
    end
  end

  assign fin = fin_q;
  assign quo = quo_q[OUT_W-1:0];
endmodule

// File: rtl/scl_axis_prep.sv
module scl_axis_prep
  import scl_pkg::*;
#(
  parameter int SZ_W    = 13,
  parameter int NUM_W   = 29,
  parameter bit IS_VERT = 1'b0
) (
  input  logic [SZ_W-1:0]  src,
  input  logic [SZ_W-1:0]  dst,
  input  logic             filt_avg,
  output scl_dir_e         dir,
  output logic [NUM_W-1:0] num,
  output logic [SZ_W-1:0]  den,
  output logic [1:0]       post_sh,
  output logic [2:0]       skip
);
  localparam int X_W = SZ_W + 2;

  logic [X_W-1:0]   s_x, d_x, act, base;
  logic [1:0]       lg;
  logic             skip_on, ge4, ge2, eq;
  logic [NUM_W-1:0] b2;

  always_comb begin
    dir     = dir_of(16'(src), 16'(dst));
    s_x     = X_W'(src);
    d_x     = X_W'(dst);
    ge4     = s_x >= (d_x << 2);
    ge2     = s_x >= (d_x << 1);
    skip_on = IS_VERT && (dir == DIR_SHRINK) && !filt_avg;
    if (!skip_on)  lg = 2'd0;
    else if (ge4)  lg = 2'd2;
    else if (ge2)  lg = 2'd1;
    else           lg = 2'd0;
    case (lg)
      2'd2:    act = (s_x + X_W'(3)) >> 2;
      2'd1:    act = (s_x + X_W'(1)) >> 1;
      default: act = s_x;
    endcase
    eq      = (lg != 2'd0) && (act == d_x);
    base    = eq ? s_x : act;
    post_sh = eq ? lg : 2'd0;
    skip    = 3'(1 << lg);
    b2      = (NUM_W'(base) << 1) - NUM_W'(3);
    num     = (dir == DIR_GROW) ? (b2 << SH_GROW) : (b2 << SH_SHRINK);
    den     = dst - 1'b1;
  end
endmodule

// File: rtl/scl_setup_calc.sv
module scl_setup_calc
  import scl_pkg::*;
#(
  parameter int SZ_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SZ_W-1:0] src_w,
  input  logic [SZ_W-1:0] src_h,
  input  logic [SZ_W-1:0] dst_w,
  input  logic [SZ_W-1:0] dst_h,
  input  logic            is_yuv,
  input  logic            filt_sel,
  output logic            busy,
  output logic            done,
  output logic            cfg_err,
  output logic [1:0]      h_dir,
  output logic [1:0]      v_dir,
  output logic [15:0]     h_factor,
  output logic [15:0]     v_factor,
  output logic [2:0]      v_skip,
  output logic [2:0]      lb_mode
);
  localparam int NUM_W = SZ_W + 16;

  typedef enum logic [2:0] {ST_IDLE, ST_HSET, ST_HDIV, ST_VSET, ST_VDIV, ST_FIN} st_e;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  st_e              st_q, st_n;
  logic             ld, pub;
  logic [SZ_W-1:0]  sw_q, sh_q, dw_q, dh_q;
  logic             yuv_q, filt_q, err;
  scl_dir_e         hd, vd;
  logic [NUM_W-1:0] h_num, v_num, div_num;
  logic [SZ_W-1:0]  h_den, v_den, div_den;
  logic [1:0]       h_post, v_post;
  logic [2:0]       h_skip_unused_n, v_sk;
  logic             div_go, div_fin;
  logic [FACT_W-1:0] div_quo, hfac_q, hfac_n, vfac_q, vfac_n;
  logic             done_n;

  assign ld  = (st_q == ST_IDLE) && start;
  assign pub = (st_q == ST_FIN);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0;
      yuv_q <= 1'b0; filt_q <= 1'b0;
    end else if (ld) begin
      sw_q <= src_w; sh_q <= src_h; dw_q <= dst_w; dh_q <= dst_h;
      yuv_q <= is_yuv; filt_q <= filt_sel;
    end
  end

  assign err = (sw_q < SZ_W'(2)) || (sh_q < SZ_W'(2)) ||
               (dw_q < SZ_W'(2)) || (dh_q < SZ_W'(2));

  scl_axis_prep #(.SZ_W(SZ_W), .NUM_W(NUM_W), .IS_VERT(1'b0)) u_hprep (
    .src(sw_q), .dst(dw_q), .filt_avg(filt_q), .dir(hd), .num(h_num),
    .den(h_den), .post_sh(h_post), .skip(h_skip_unused_n)
  );

  scl_axis_prep #(.SZ_W(SZ_W), .NUM_W(NUM_W), .IS_VERT(1'b1)) u_vprep (
    .src(sh_q), .dst(dh_q), .filt_avg(filt_q), .dir(vd), .num(v_num),
    .den(v_den), .post_sh(v_post), .skip(v_sk)
  );

  scl_rdiv #(.NUM_W(NUM_W), .DEN_W(SZ_W), .OUT_W(FACT_W)) u_div (
    .clk(clk), .rst_n(arst_n), .go(div_go), .num(div_num), .den(div_den),
    .fin(div_fin), .quo(div_quo)
  );

  always_comb begin
    st_n    = st_q;
    hfac_n  = hfac_q;
    vfac_n  = vfac_q;
    div_go  = 1'b0;
    div_num = h_num;
    div_den = h_den;
    done_n  = 1'b0;
    case (st_q)
      ST_IDLE: if (start) st_n = ST_HSET;
      ST_HSET: begin
        if (!err && hd != DIR_KEEP) begin
          div_go = 1'b1;
          st_n   = ST_HDIV;
        end else begin
          hfac_n = err ? '0 : FACT_UNITY;
          st_n   = ST_VSET;
        end
      end
      ST_HDIV: if (div_fin) begin
        hfac_n = div_quo >> h_post;
        st_n   = ST_VSET;
      end
      ST_VSET: begin
        div_num = v_num;
        div_den = v_den;
        if (!err && vd != DIR_KEEP) begin
          div_go = 1'b1;
          st_n   = ST_VDIV;
        end else begin
          vfac_n = err ? '0 : FACT_UNITY;
          st_n   = ST_FIN;
        end
      end
      ST_VDIV: if (div_fin) begin
        vfac_n = div_quo >> v_post;
        st_n   = ST_FIN;
      end
      ST_FIN: begin
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_IDLE;
      hfac_q <= '0;
      vfac_q <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_n;
      hfac_q <= hfac_n;
      vfac_q <= vfac_n;
      done   <= done_n;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      h_factor <= '0; v_factor <= '0; h_dir <= '0; v_dir <= '0;
      v_skip <= '0; lb_mode <= '0; cfg_err <= 1'b0;
    end else if (pub) begin
      h_factor <= hfac_q;
      v_factor <= vfac_q;
      h_dir    <= hd;
      v_dir    <= vd;
      v_skip   <= err ? 3'd1 : v_sk;
      lb_mode  <= lb_pick(16'(sw_q), yuv_q);
      cfg_err  <= err;
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/scl_setup_calc_chk.sv
module scl_setup_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        cfg_err,
  input logic [1:0]  h_dir,
  input logic [1:0]  v_dir,
  input logic [15:0] h_factor,
  input logic [15:0] v_factor,
  input logic [2:0]  v_skip,
  input logic [2:0]  lb_mode
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_h_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_factor) |-> done);
  assert_hold_v_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_factor) |-> done);
  assert_dir_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (h_dir != 2'd3) && (v_dir != 2'd3));
  assert_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_err && h_dir == 2'd0) |-> h_factor == 16'h1000);
  assert_skip_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(v_skip) == 1) && (v_skip != 3'd0));
  assert_skip_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && v_skip != 3'd1) |-> v_dir == 2'd2);
  assert_lb_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lb_mode <= 3'd4);
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_err) |-> (h_factor == 16'd0) && (v_factor == 16'd0) && (v_skip == 3'd1));
endmodule

bind scl_setup_calc scl_setup_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cfg_err(cfg_err),
  .h_dir(h_dir), .v_dir(v_dir), .h_factor(h_factor), .v_factor(v_factor),
  .v_skip(v_skip), .lb_mode(lb_mode)
);

// File: tb/scl_setup_calc_bench.sv
`timescale 1ns/1ps
module scl_setup_calc_bench;
  localparam int SZ_W = 13;

  logic            clk, rst_n, start, is_yuv, filt_sel;
  logic [SZ_W-1:0] src_w, src_h, dst_w, dst_h;
  logic            busy, done, cfg_err;
  logic [1:0]      h_dir, v_dir;
  logic [15:0]     h_factor, v_factor;
  logic [2:0]      v_skip, lb_mode;

  scl_setup_calc #(.SZ_W(SZ_W)) u_scl_setup_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .src_w(src_w), .src_h(src_h),
    .dst_w(dst_w), .dst_h(dst_h), .is_yuv(is_yuv), .filt_sel(filt_sel),
    .busy(busy), .done(done), .cfg_err(cfg_err), .h_dir(h_dir), .v_dir(v_dir),
    .h_factor(h_factor), .v_factor(v_factor), .v_skip(v_skip), .lb_mode(lb_mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int hd; int vd; int hf; int vf; int sk; int lb; int er; string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   cyc     = 0;
  bit   ended   = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic int dir_of(int s, int d);
    return (s == d) ? 0 : (s < d) ? 1 : 2;
  endfunction

  function automatic int fac(int s, int d, int sh);
    longint n;
    n = longint'(2 * s - 3) << (sh - 1);
    return int'(n / longint'(d - 1)) & 16'hFFFF;
  endfunction

  function automatic exp_t model(int sw, int sh, int dw, int dh, bit yuv, bit flt, string tag);
    exp_t e;
    int lg, k, act;
    e.tag = tag;
    e.hd  = dir_of(sw, dw);
    e.vd  = dir_of(sh, dh);
    e.er  = (sw < 2 || sh < 2 || dw < 2 || dh < 2) ? 1 : 0;
    if (sw > 2560)      e.lb = 2;
    else if (sw > 1920) e.lb = 3;
    else if (!yuv)      e.lb = 4;
    else if (sw > 1280) e.lb = 0;
    else                e.lb = 1;
    // R4/R5/R6 horizontal
    if (e.hd == 0)      e.hf = 4096;
    else if (e.hd == 1) e.hf = fac(sw, dw, 16);
    else                e.hf = fac(sw, dw, 12);
    // R7/R8 vertical
    e.sk = 1;
    if (e.vd == 0)      e.vf = 4096;
    else if (e.vd == 1) e.vf = fac(sh, dh, 16);
    else if (flt)       e.vf = fac(sh, dh, 12);
    else begin
      lg   = (sh >= 4 * dh) ? 2 : (sh >= 2 * dh) ? 1 : 0;
      k    = 1 << lg;
      e.sk = k;
      act  = (sh + k - 1) / k;
      if (lg != 0 && act == dh) e.vf = fac(sh, dh, 12) / k;
      else                      e.vf = fac(act, dh, 12);
    end
    if (e.er != 0) begin
      e.hf = 0; e.vf = 0; e.sk = 1;
    end
    return e;
  endfunction

  // monitor: compares every published result with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(h_dir) == e.hd, {"R3 h_dir ", e.tag}, h_dir, e.hd);
        check(int'(v_dir) == e.vd, {"R3 v_dir ", e.tag}, v_dir, e.vd);
        check(int'(h_factor) == e.hf, {"R4/R5/R6 h_factor ", e.tag}, h_factor, e.hf);
        check(int'(v_factor) == e.vf, {"R5/R6/R8 v_factor ", e.tag}, v_factor, e.vf);
        check(int'(v_skip) == e.sk, {"R7 v_skip ", e.tag}, v_skip, e.sk);
        check(int'(lb_mode) == e.lb, {"R9 lb_mode ", e.tag}, lb_mode, e.lb);
        check(int'(cfg_err) == e.er, {"R10 cfg_err ", e.tag}, cfg_err, e.er);
        check(!busy, {"R1 busy low at done ", e.tag}, busy, 0);
      end
    end
  end

  // driver: called right after a falling edge
  task automatic launch(input int sw, input int sh, input int dw, input int dh,
                        input bit yuv, input bit flt, input string tag);
    exp_q.push_back(model(sw, sh, dw, dh, yuv, flt, tag));
    src_w = SZ_W'(sw); src_h = SZ_W'(sh); dst_w = SZ_W'(dw); dst_h = SZ_W'(dh);
    is_yuv = yuv; filt_sel = flt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, {"R1 busy after start ", tag}, busy, 1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic job(input int sw, input int sh, input int dw, input int dh,
                     input bit yuv, input bit flt, input string tag);
    launch(sw, sh, dw, dh, yuv, flt, tag);
    wait_done();
  endtask

  initial begin
    logic [15:0] hold_h, hold_v;
    rst_n = 1'b0; start = 1'b0; is_yuv = 1'b0; filt_sel = 1'b0;
    src_w = '0; src_h = '0; dst_w = '0; dst_h = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!done && !busy && !cfg_err, "R1 reset flags", {done, busy, cfg_err}, 0);
    check(h_factor == 0 && v_factor == 0 && v_skip == 0 && lb_mode == 0,
          "R1 reset results", h_factor, 0);

    // back-to-back chain: each launch lands in the done cycle (R11)
    job(1920, 1080, 1920, 1080, 0, 0, "keep both R4");
    job(1280, 720, 1920, 1080, 1, 0, "grow bilinear R5");
    job(1280, 720, 1920, 1080, 0, 1, "grow bicubic R5 R11");
    job(3840, 2160, 1920, 1080, 0, 0, "shrink skip2 equal R8");
    job(2000, 4000, 1000, 1000, 1, 0, "skip4 equal R8");
    job(2000, 4000, 1000, 1000, 1, 1, "average no skip R7");
    job(800, 3000, 640, 700, 1, 0, "skip4 effective R8");
    job(1600, 1500, 1000, 1000, 1, 0, "skip1 shrink R6");
    job(4000, 3999, 1000, 1000, 0, 0, "skip2 boundary R7");
    job(640, 480, 1280, 960, 1, 0, "mixed grow R3");
    job(2561, 700, 1000, 1400, 1, 0, "lb over hi R9");
    job(2560, 1400, 3000, 700, 1, 0, "lb at hi R9");
    job(1921, 100, 1921, 50, 1, 0, "lb over mid R9");
    job(1920, 100, 1000, 100, 1, 0, "lb at mid yuv R9");
    job(1281, 300, 1281, 300, 1, 0, "lb over lo R9");
    job(1280, 300, 100, 300, 1, 0, "lb at lo R9");
    job(1000, 800, 1, 400, 0, 0, "err dst_w R10");
    job(1000, 1, 500, 500, 1, 0, "err src_h R10");
    job(3, 2, 2, 3, 0, 0, "small sizes R5 R6");

    // R2: a start mid-job is ignored
    repeat (3) @(negedge clk);
    hold_h = h_factor; hold_v = v_factor;
    launch(1000, 900, 500, 300, 0, 0, "first of overlap R2");
    repeat (5) @(negedge clk);
    src_w = 13'd77; src_h = 13'd88; dst_w = 13'd99; dst_h = 13'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2 still busy after extra start", busy, 1);
    check(h_factor == hold_h && v_factor == hold_v, "R2 results held mid-job", h_factor, hold_h);
    wait_done();
    @(negedge clk);
    check(!busy, "R2 no job follows ignored start", busy, 0);
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, "R2 no extra result", exp_q.size(), 0);
    check(!done, "R2 idle done low", done, 0);
    finish_run();
  end
endmodule